// File: doc/BRIEF.md
# Zero-Delimited COBS Request Receiver with CRC-32 Check

This block takes a byte stream from a serial receiver and cuts it into frames. A zero byte closes a frame. Every other byte belongs to the frame that is open. The frame is COBS-decoded as its bytes arrive. The decoded payload must be exactly eight bytes: a 32-bit request sequence number followed by a CRC-32 over that number. When a frame passes every check, the sequence number is latched and a one-cycle valid pulse is raised.

A frame that fails is counted in exactly one of three error counters: decode, length or CRC. A fourth counter records raw bytes that were dropped because the frame store was already full. All four counters saturate. Reading and acting on them is left to the surrounding logic.

Top module: `cobs_frame_rx`

## Requirements
- R1: A byte of 0x00 closes the frame that is open, and any other byte is added to it. The frame fill index returns to zero at every zero byte, whatever the outcome, so a good frame sent right after a bad one is accepted.
- R2: Decoding follows COBS. A code byte n is followed by n-1 data bytes that are copied out. A zero is inserted after them unless n is 0xFF or the frame has ended. Payload bytes of zero therefore round-trip.
- R3: When a code byte claims more data bytes than remain before the closing zero, the frame is a decode error and increments cobs_err_cnt_o.
- R4: A frame whose decoded payload is not exactly 8 bytes increments len_err_cnt_o. This includes an empty frame and a frame that decodes to nothing.
- R5: Payload bytes 0..3 hold the sequence number and bytes 4..7 hold the CRC, both least significant byte first. The CRC is reflected CRC-32 (polynomial 0x04C11DB7, seed 0xFFFFFFFF, output inverted) over bytes 0..3 only. A mismatch increments crc_err_cnt_o.
- R6: A computed CRC of 0x00000000 or 0xFFFFFFFF is counted as a CRC error, even when the received CRC equals it.
- R7: On a frame that passes, seq_o takes the sequence number and seq_valid_o is high for exactly one cycle. Both changes appear one clock after the closing zero byte is sampled. seq_o does not change at any other time.
- R8: The frame store holds BUF_DEPTH (default 512) raw bytes. Each non-zero byte that arrives while it is full is dropped and increments overrun_cnt_o by one. The kept bytes are still decoded when the closing zero arrives.
- R9: Every counter is CNT_W bits wide (default 32) and holds at its all-ones value instead of wrapping.
- R10: Each frame has exactly one outcome, with decode error first, then length error, then CRC error, then accept. No two counters move in the same cycle, and no counter moves when seq_valid_o is high.
- R11: After reset, seq_o, seq_valid_o and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | byte_i carries a received byte this cycle |
| byte_i | input | 8 | Received byte |
| seq_o | output | 32 | Sequence number of the last accepted frame |
| seq_valid_o | output | 1 | One-cycle pulse when seq_o is updated |
| overrun_cnt_o | output | CNT_W | Bytes dropped because the store was full |
| cobs_err_cnt_o | output | CNT_W | Frames that failed COBS decoding |
| len_err_cnt_o | output | CNT_W | Frames whose decoded length was not 8 |
| crc_err_cnt_o | output | CNT_W | Frames with a CRC mismatch or a degenerate CRC |

## Verification
The bench sends sequence numbers that contain zero bytes. A decoder that drops or misplaces inserted zeros would then report CRC or length errors on good frames. It solves for sequence numbers whose CRC is all-zeros and all-ones and sends them with matching trailers; a design that trusted any match would accept them. A frame that is both truncated and short checks that only the decode counter moves. Bursts beyond the store capacity, run with a 4-bit counter build, check that overruns are counted once per dropped byte, that the counter holds at its maximum, and that the next good frame is still accepted.

// File: rtl/cobs_rx_pkg.sv
package cobs_rx_pkg;
  localparam logic [31:0] CRC_POLY_R = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED   = 32'hFFFFFFFF;
  localparam int SEQ_BYTES   = 4;
  localparam int CRC_BYTES   = 4;
  localparam int FRAME_BYTES = SEQ_BYTES + CRC_BYTES;
  localparam int SEQ_W       = 8 * SEQ_BYTES;

  typedef enum logic [2:0] {
    VERD_NONE,
    VERD_OK,
    VERD_COBS,
    VERD_LEN,
    VERD_CRC
  } verdict_e;

  // one byte through the reflected CRC-32 register
  function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/cobs_stream_decoder.sv
module cobs_stream_decoder #(
  parameter int DEPTH = 512
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       byte_valid_i,
  input  logic [7:0] byte_i,
  output logic       dec_valid_o,
  output logic [7:0] dec_byte_o,
  output logic       frame_end_o,
  output logic       cobs_err_o,
  output logic       overrun_o
);
  localparam int FILL_W = $clog2(DEPTH + 1);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(DEPTH);

  logic [FILL_W-1:0] fill_q;
  logic [7:0]        remain_q;
  logic              pend_zero_q;
  logic              is_delim, is_data, buf_full, accept;

  assign is_delim = byte_valid_i && (byte_i == 8'h00);
  assign is_data  = byte_valid_i && (byte_i != 8'h00);
  assign buf_full = (fill_q == FILL_MAX);
  assign accept   = is_data && !buf_full;

  assign overrun_o   = is_data && buf_full;
  assign frame_end_o = is_delim;
  assign cobs_err_o  = is_delim && (remain_q != 8'h00);

  always_comb begin
    dec_valid_o = 1'b0;
    dec_byte_o  = 8'h00;
    if (accept) begin
      if (remain_q == 8'h00) begin
        // new code byte: emit the zero owed by the previous block
        dec_valid_o = pend_zero_q;
      end else begin
        dec_valid_o = 1'b1;
        dec_byte_o  = byte_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q      <= '0;
      remain_q    <= 8'h00;
      pend_zero_q <= 1'b0;
    end else if (is_delim) begin
      fill_q      <= '0;
      remain_q    <= 8'h00;
      pend_zero_q <= 1'b0;
    end else if (accept) begin
      fill_q <= fill_q + 1'b1;
      if (remain_q == 8'h00) begin
        remain_q    <= byte_i - 8'd1;
        pend_zero_q <= (byte_i != 8'hFF);
      end else begin
        remain_q <= remain_q - 8'd1;
      end
    end
  end
endmodule

// File: rtl/crc32_engine.sv
module crc32_engine (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clear_i,
  input  logic        en_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] crc_o
);
  import cobs_rx_pkg::*;

  logic [31:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_q <= CRC_SEED;
    else if (clear_i) state_q <= CRC_SEED;
    else if (en_i)    state_q <= crc32_byte(state_q, byte_i);
  end

  assign crc_o = ~state_q;
endmodule

// File: rtl/frame_checker.sv
module frame_checker
  import cobs_rx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dec_valid_i,
  input  logic [7:0]       dec_byte_i,
  input  logic             frame_end_i,
  input  logic             cobs_err_i,
  output verdict_e         verdict_o,
  output logic [SEQ_W-1:0] seq_o
);
  localparam int LEN_W = $clog2(FRAME_BYTES + 2);
  localparam logic [LEN_W-1:0] LEN_SAT  = LEN_W'(FRAME_BYTES + 1);
  localparam logic [LEN_W-1:0] LEN_GOOD = LEN_W'(FRAME_BYTES);
  localparam logic [LEN_W-1:0] LEN_SEQ  = LEN_W'(SEQ_BYTES);
  localparam int CRC_W = 8 * CRC_BYTES;

  logic [LEN_W-1:0] len_q;
  logic [SEQ_W-1:0] seq_sr_q;
  logic [CRC_W-1:0] crc_rx_q;
  logic [31:0]      crc_calc;
  logic             crc_en;

  assign crc_en = dec_valid_i && (len_q < LEN_SEQ);

  crc32_engine u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(frame_end_i),
    .en_i   (crc_en),
    .byte_i (dec_byte_i),
    .crc_o  (crc_calc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q    <= '0;
      seq_sr_q <= '0;
      crc_rx_q <= '0;
    end else if (frame_end_i) begin
      len_q <= '0;
    end else if (dec_valid_i) begin
      if (len_q < LEN_SAT) len_q <= len_q + 1'b1;
      // little-endian fields: earliest byte ends up least significant
      if (len_q < LEN_SEQ)       seq_sr_q <= {dec_byte_i, seq_sr_q[SEQ_W-1:8]};
      else if (len_q < LEN_GOOD) crc_rx_q <= {dec_byte_i, crc_rx_q[CRC_W-1:8]};
    end
  end

  always_comb begin
    verdict_o = VERD_NONE;
    if (frame_end_i) begin
      if (cobs_err_i)                      verdict_o = VERD_COBS;
      else if (len_q != LEN_GOOD)          verdict_o = VERD_LEN;
      else if ((crc_calc != crc_rx_q) ||
               (crc_calc == 32'h0000_0000) ||
               (crc_calc == 32'hFFFF_FFFF)) verdict_o = VERD_CRC;
      else                                 verdict_o = VERD_OK;
    end
  end

  assign seq_o = seq_sr_q;
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_o <= '0;
    else if (inc_i && ~&cnt_o)     cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/cobs_frame_rx.sv
module cobs_frame_rx
  import cobs_rx_pkg::*;
#(
  parameter int BUF_DEPTH = 512,
  parameter int CNT_W     = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_i,
  output logic [31:0]      seq_o,
  output logic             seq_valid_o,
  output logic [CNT_W-1:0] overrun_cnt_o,
  output logic [CNT_W-1:0] cobs_err_cnt_o,
  output logic [CNT_W-1:0] len_err_cnt_o,
  output logic [CNT_W-1:0] crc_err_cnt_o
);
  localparam int N_CNT = 4;

  logic             dec_valid, frame_end, cobs_err, overrun;
  logic [7:0]       dec_byte;
  verdict_e         verdict;
  logic [SEQ_W-1:0] seq_cand;
  logic [N_CNT-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_val [N_CNT];

  cobs_stream_decoder #(.DEPTH(BUF_DEPTH)) u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_valid_i(byte_valid_i),
    .byte_i      (byte_i),
    .dec_valid_o (dec_valid),
    .dec_byte_o  (dec_byte),
    .frame_end_o (frame_end),
    .cobs_err_o  (cobs_err),
    .overrun_o   (overrun)
  );

  frame_checker u_chk_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dec_valid_i(dec_valid),
    .dec_byte_i (dec_byte),
    .frame_end_i(frame_end),
    .cobs_err_i (cobs_err),
    .verdict_o  (verdict),
    .seq_o      (seq_cand)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_o       <= '0;
      seq_valid_o <= 1'b0;
    end else begin
      seq_valid_o <= (verdict == VERD_OK);
      if (verdict == VERD_OK) seq_o <= seq_cand;
    end
  end

  assign cnt_inc = {verdict == VERD_CRC, verdict == VERD_LEN, verdict == VERD_COBS, overrun};

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    sat_counter #(.W(CNT_W)) u_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .inc_i (cnt_inc[g]),
      .cnt_o (cnt_val[g])
    );
  end

  assign overrun_cnt_o  = cnt_val[0];
  assign cobs_err_cnt_o = cnt_val[1];
  assign len_err_cnt_o  = cnt_val[2];
  assign crc_err_cnt_o  = cnt_val[3];
endmodule

// File: rtl/cobs_frame_rx_chk.sv
module cobs_frame_rx_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             byte_valid_i,
  input logic [7:0]       byte_i,
  input logic [31:0]      seq_o,
  input logic             seq_valid_o,
  input logic [CNT_W-1:0] overrun_cnt_o,
  input logic [CNT_W-1:0] cobs_err_cnt_o,
  input logic [CNT_W-1:0] len_err_cnt_o,
  input logic [CNT_W-1:0] crc_err_cnt_o
);
  // R7
  seq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_valid_o |=> !seq_valid_o);

  // R7
  seq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(seq_o) |-> seq_valid_o);

  // R1
  valid_after_delim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_valid_o |-> $past(byte_valid_i && (byte_i == 8'h00)));

  // R10
  one_outcome_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({seq_valid_o, !$stable(overrun_cnt_o), !$stable(cobs_err_cnt_o),
                !$stable(len_err_cnt_o), !$stable(crc_err_cnt_o)}) <= 1);

  // R8
  overrun_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(overrun_cnt_o) |-> $past(byte_valid_i && (byte_i != 8'h00)));

  // R9
  overrun_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(overrun_cnt_o) |-> overrun_cnt_o == $past(overrun_cnt_o) + 1'b1);

  // R9
  cobs_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cobs_err_cnt_o) |-> cobs_err_cnt_o == $past(cobs_err_cnt_o) + 1'b1);

  // R9
  len_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(len_err_cnt_o) |-> len_err_cnt_o == $past(len_err_cnt_o) + 1'b1);

  // R9
  crc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(crc_err_cnt_o) |-> crc_err_cnt_o == $past(crc_err_cnt_o) + 1'b1);
endmodule

bind cobs_frame_rx cobs_frame_rx_chk #(.CNT_W(CNT_W)) u_rx_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .byte_valid_i  (byte_valid_i),
  .byte_i        (byte_i),
  .seq_o         (seq_o),
  .seq_valid_o   (seq_valid_o),
  .overrun_cnt_o (overrun_cnt_o),
  .cobs_err_cnt_o(cobs_err_cnt_o),
  .len_err_cnt_o (len_err_cnt_o),
  .crc_err_cnt_o (crc_err_cnt_o)
);

// File: tb/cobs_frame_rx_bench.sv
module cobs_frame_rx_bench;
  localparam int DEPTH = 512;
  localparam int CW    = 4;
  localparam int MAXC  = (1 << CW) - 1;

  typedef bit [7:0] bq_t[$];
  typedef enum int {EV_OK = 0, EV_OVR = 1, EV_COBS = 2, EV_LEN = 3, EV_CRC = 4} ev_e;
  typedef struct {
    ev_e         kind;
    logic [31:0] seq;
    string       req;
  } exp_t;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          byte_valid_i = 1'b0;
  logic [7:0]    byte_i = 8'h00;
  logic [31:0]   seq_o;
  logic          seq_valid_o;
  logic [CW-1:0] overrun_cnt_o, cobs_err_cnt_o, len_err_cnt_o, crc_err_cnt_o;

  cobs_frame_rx #(.BUF_DEPTH(DEPTH), .CNT_W(CW)) u_cobs_frame_rx (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .byte_valid_i  (byte_valid_i),
    .byte_i        (byte_i),
    .seq_o         (seq_o),
    .seq_valid_o   (seq_valid_o),
    .overrun_cnt_o (overrun_cnt_o),
    .cobs_err_cnt_o(cobs_err_cnt_o),
    .len_err_cnt_o (len_err_cnt_o),
    .crc_err_cnt_o (crc_err_cnt_o)
  );

  always #5 clk_i = ~clk_i;

  exp_t        exp_q[$];
  int          vectors = 0, miscompares = 0;
  int          mdl_cnt[1:4];
  int          fill = 0;
  bit          done = 0;
  logic [31:0] mon_seq = '0;
  logic [CW-1:0] p_ovr = '0, p_cobs = '0, p_len = '0, p_crc = '0;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit [31:0] ref_crc(bit [31:0] w);
    bit [31:0] c = 32'hFFFFFFFF;
    for (int k = 0; k < 4; k++) begin
      c ^= {24'h0, w[8*k +: 8]};
      for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  // solve ref_crc(x) == target; the map is affine and bijective over GF(2)
  function automatic bit [31:0] crc_preimage(bit [31:0] target);
    bit [31:0] pv[32];
    bit [31:0] pc[32];
    bit        have[32];
    bit [31:0] c0, v, m, t;
    c0 = ref_crc(32'h0);
    for (int b = 0; b < 32; b++) have[b] = 0;
    for (int i = 0; i < 32; i++) begin
      v = ref_crc(32'h1 << i) ^ c0;
      m = 32'h1 << i;
      for (int b = 31; b >= 0; b--) begin
        if (v[b]) begin
          if (have[b]) begin
            v ^= pv[b];
            m ^= pc[b];
          end else begin
            pv[b] = v; pc[b] = m; have[b] = 1;
            break;
          end
        end
      end
    end
    t = target ^ c0;
    m = '0;
    for (int b = 31; b >= 0; b--) begin
      if (t[b] && have[b]) begin
        t ^= pv[b];
        m ^= pc[b];
      end
    end
    return m;
  endfunction

  function automatic bq_t mk_payload(bit [31:0] s, bit [31:0] c);
    bq_t p;
    for (int k = 0; k < 4; k++) p.push_back(s[8*k +: 8]);
    for (int k = 0; k < 4; k++) p.push_back(c[8*k +: 8]);
    return p;
  endfunction

  function automatic bq_t cobs_enc(bq_t p);
    bq_t o;
    int  ci, code;
    o.push_back(8'h00);
    ci = 0; code = 1;
    foreach (p[i]) begin
      if (p[i] == 8'h00) begin
        o[ci] = 8'(code); ci = o.size(); o.push_back(8'h00); code = 1;
      end else begin
        o.push_back(p[i]); code++;
        if (code == 255) begin
          o[ci] = 8'(code); ci = o.size(); o.push_back(8'h00); code = 1;
        end
      end
    end
    o[ci] = 8'(code);
    return o;
  endfunction

  task automatic expect_ev(ev_e k, logic [31:0] s, string req);
    exp_t e;
    e.kind = k; e.seq = s; e.req = req;
    if (k == EV_OK) exp_q.push_back(e);
    else if (mdl_cnt[int'(k)] < MAXC) begin
      mdl_cnt[int'(k)]++;
      exp_q.push_back(e);
    end
  endtask

  task automatic put_byte(bit [7:0] b);
    @(negedge clk_i);
    byte_valid_i = 1'b1;
    byte_i = b;
    if (b != 8'h00) begin
      if (fill >= DEPTH) expect_ev(EV_OVR, '0, "R8");
      else fill++;
    end else fill = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      byte_valid_i = 1'b0;
      byte_i = 8'h00;
    end
  endtask

  task automatic send_frame(bq_t raw, ev_e k, logic [31:0] s, string req);
    foreach (raw[i]) put_byte(raw[i]);
    put_byte(8'h00);
    expect_ev(k, s, req);
    idle(2);
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      ev_e obs;
      bit  any;
      exp_t e;
      any = 1;
      if (seq_valid_o)                  obs = EV_OK;
      else if (overrun_cnt_o != p_ovr)  obs = EV_OVR;
      else if (cobs_err_cnt_o != p_cobs) obs = EV_COBS;
      else if (len_err_cnt_o != p_len)  obs = EV_LEN;
      else if (crc_err_cnt_o != p_crc)  obs = EV_CRC;
      else begin any = 0; obs = EV_OK; end
      if (any) begin
        if (exp_q.size() == 0) begin
          check(0, "R10", "unexpected event", 32'(int'(obs)), 32'hFFFFFFFF);
        end else begin
          e = exp_q.pop_front();
          check(obs == e.kind, e.req, "outcome", 32'(int'(obs)), 32'(int'(e.kind)));
          if (e.kind == EV_OK) mon_seq = e.seq;
          // R7: seq_o carries the last accepted number, also after rejects
          check(seq_o == mon_seq, e.req, "seq_o", seq_o, mon_seq);
        end
      end
      p_ovr = overrun_cnt_o; p_cobs = cobs_err_cnt_o;
      p_len = len_err_cnt_o; p_crc = crc_err_cnt_o;
    end
  end

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    bq_t         raw, pl;
    bit   [31:0] s, x0, x1;
    for (int k = 1; k <= 4; k++) mdl_cnt[k] = 0;

    repeat (3) @(negedge clk_i);
    // R11
    check(seq_o == '0, "R11", "seq_o reset", seq_o, '0);
    check(seq_valid_o == 1'b0, "R11", "seq_valid_o reset", 32'(seq_valid_o), '0);
    check(overrun_cnt_o == '0, "R11", "overrun reset", 32'(overrun_cnt_o), '0);
    check(cobs_err_cnt_o == '0, "R11", "cobs reset", 32'(cobs_err_cnt_o), '0);
    check(len_err_cnt_o == '0, "R11", "len reset", 32'(len_err_cnt_o), '0);
    check(crc_err_cnt_o == '0, "R11", "crc reset", 32'(crc_err_cnt_o), '0);
    rst_ni = 1'b1;
    idle(2);

    // R7 R5: plain good frame
    s = 32'h12345678;
    send_frame(cobs_enc(mk_payload(s, ref_crc(s))), EV_OK, s, "R7");

    // R2: zero bytes in payload
    s = 32'h00A10000;
    send_frame(cobs_enc(mk_payload(s, ref_crc(s))), EV_OK, s, "R2");
    s = 32'h00000000;
    send_frame(cobs_enc(mk_payload(s, ref_crc(s))), EV_OK, s, "R2");

    // R5: CRC mismatch, seq_o must keep 0
    s = 32'hCAFEF00D;
    send_frame(cobs_enc(mk_payload(s, ref_crc(s) ^ 32'h1)), EV_CRC, '0, "R5");

    // R6: matching but degenerate CRCs
    x0 = crc_preimage(32'h00000000);
    send_frame(cobs_enc(mk_payload(x0, 32'h00000000)), EV_CRC, '0, "R6");
    x1 = crc_preimage(32'hFFFFFFFF);
    send_frame(cobs_enc(mk_payload(x1, 32'hFFFFFFFF)), EV_CRC, '0, "R6");

    // R4: wrong lengths
    s = 32'h01020304;
    pl = mk_payload(s, ref_crc(s));
    void'(pl.pop_back());
    send_frame(cobs_enc(pl), EV_LEN, '0, "R4");
    pl = mk_payload(s, ref_crc(s));
    pl.push_back(8'h55);
    send_frame(cobs_enc(pl), EV_LEN, '0, "R4");
    raw = {};
    send_frame(raw, EV_LEN, '0, "R4");
    raw = {8'h01};
    send_frame(raw, EV_LEN, '0, "R4");

    // R3 R10: truncated code block, also short, only decode error counts
    raw = {8'h05, 8'h11, 8'h22};
    send_frame(raw, EV_COBS, '0, "R3");

    // R1: good frame right after errors
    s = 32'h0BADBEEF;
    send_frame(cobs_enc(mk_payload(s, ref_crc(s))), EV_OK, s, "R1");

    // R8: three bytes past capacity, then a good frame
    raw = {};
    for (int i = 0; i < DEPTH + 3; i++) raw.push_back(8'h01);
    send_frame(raw, EV_LEN, '0, "R8");
    s = 32'h7E570001;
    send_frame(cobs_enc(mk_payload(s, ref_crc(s))), EV_OK, s, "R1");

    // R9: drive overrun counter into saturation
    raw = {};
    for (int i = 0; i < DEPTH + 20; i++) raw.push_back(8'h01);
    send_frame(raw, EV_LEN, '0, "R9");
    s = 32'h55AA33CC;
    send_frame(cobs_enc(mk_payload(s, ref_crc(s))), EV_OK, s, "R8");

    idle(5);
    check(exp_q.size() == 0, "R10", "pending expectations", 32'(exp_q.size()), '0);
    // R9
    check(overrun_cnt_o == CW'(MAXC), "R9", "overrun saturated", 32'(overrun_cnt_o), 32'(MAXC));
    check(32'(cobs_err_cnt_o) == 32'(mdl_cnt[2]), "R3", "cobs count", 32'(cobs_err_cnt_o), 32'(mdl_cnt[2]));
    check(32'(len_err_cnt_o) == 32'(mdl_cnt[3]), "R4", "len count", 32'(len_err_cnt_o), 32'(mdl_cnt[3]));
    check(32'(crc_err_cnt_o) == 32'(mdl_cnt[4]), "R6", "crc count", 32'(crc_err_cnt_o), 32'(mdl_cnt[4]));
    check(seq_o == 32'h55AA33CC, "R7", "final seq", seq_o, 32'h55AA33CC);
    finish_run();
  end
endmodule